// File: doc/BRIEF.md
# Compare Flags and Branch Resolver

This block keeps the result of the most recent compare as persistent status and uses it to decide the conditional jumps. A compare operation with the execute strobe asserted checks two 32-bit two's-complement operands against each other. It then records exactly one outcome: the operands were equal, the first was greater, or the first was less. The recorded outcome stays in place until the next executed compare. No other opcode changes it.

The status is held as a small state machine with four named states. FL_CLEAR is the reset state, in which no flag is set. FL_EQ, FL_GT and FL_LT each hold one compare outcome. The block has a single kind of transition: an executed compare moves from any state to the state that matches the comparator's result. In every other cycle the state holds.

In the same cycle as an executed jump opcode, the block compares the opcode against the stored flags and raises a taken indication. It also always presents a branch target. The target is the current program counter plus the signed 16-bit word offset, where the offset is scaled by four. The surrounding pipeline does the flushing and the fetch redirect.

Top module: `cbr_resolver`

## Requirements
- R1: After reset all three flags read 0 (state FL_CLEAR) and taken is 0 while the execute strobe is low.
- R2: An executed compare (opcode 0x14) sets exactly one flag in the following cycle. Equal is set when the operands match. Greater is set when operand A > operand B as signed 32-bit values. Less is set when A < B as signed values.
- R3: The flags do not change unless opcode 0x14 is presented with execute high. A compare with execute low leaves them as they were, and so does any other opcode with execute high.
- R4: Opcode 0x0D with execute high is always taken, whatever the flags are.
- R5: Opcode 0x0E is taken when equal is set; opcode 0x0F is taken when equal is clear.
- R6: Opcode 0x10 is taken when greater is set; opcode 0x11 is taken when greater or equal is set.
- R7: Opcode 0x12 is taken when less is set; opcode 0x13 is taken when less or equal is set.
- R8: The target equals pc + (sign-extended offset << 2), modulo 2^32. Offset bit 15 is the sign.
- R9: Taken is 0 whenever execute is low or the opcode is outside 0x0D..0x13.
- R10: A jump executed in the cycle right after a compare is resolved against the flags that compare wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute strobe for the presented opcode |
| opcode_i | input | 6 | Operation code |
| opa_i | input | 32 | First compare operand |
| opb_i | input | 32 | Second compare operand |
| pc_i | input | 32 | Current program counter |
| offset_i | input | 16 | Signed word offset of the jump |
| flag_eq_o | output | 1 | Stored equal flag |
| flag_gt_o | output | 1 | Stored greater-than flag |
| flag_lt_o | output | 1 | Stored less-than flag |
| taken_o | output | 1 | Jump resolved as taken |
| target_o | output | 32 | Jump target address |

## Verification
The flag state can be observed directly, so a wrong state or a missed update shows on the flag outputs one cycle after the compare that caused it. It also shows on taken_o in the first conditional jump that follows. Signed compare mistakes show only when the operands differ in their top bit, so the bench drives the extreme positive and negative values on purpose. Random sequences interleave compares, jumps and idle cycles so that a stale or spuriously changed flag is caught within a few cycles.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OP_JMP  = 6'h0D;
    localparam logic [OPC_W-1:0] OP_JEQ  = 6'h0E;
    localparam logic [OPC_W-1:0] OP_JNE  = 6'h0F;
    localparam logic [OPC_W-1:0] OP_JGT  = 6'h10;
    localparam logic [OPC_W-1:0] OP_JGE  = 6'h11;
    localparam logic [OPC_W-1:0] OP_JLT  = 6'h12;
    localparam logic [OPC_W-1:0] OP_JLE  = 6'h13;
    localparam logic [OPC_W-1:0] OP_CMP  = 6'h14;

    typedef enum logic [1:0] {
        FL_CLEAR = 2'd0,
        FL_EQ    = 2'd1,
        FL_GT    = 2'd2,
        FL_LT    = 2'd3
    } flag_state_t;

    typedef struct packed {
        logic eq;
        logic gt;
        logic lt;
    } flag_bits_t;

endpackage

// File: rtl/cbr_compare.sv
module cbr_compare
    import cbr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output flag_state_t       result_o
);

    logic signed [DATA_W-1:0] sa;
    logic signed [DATA_W-1:0] sb;

    assign sa = opa_i;
    assign sb = opb_i;

    always_comb begin
        if (sa == sb) begin
            result_o = FL_EQ;
        end else if (sa > sb) begin
            result_o = FL_GT;
        end else begin
            result_o = FL_LT;
        end
    end

endmodule

// File: rtl/cbr_flag_fsm.sv
module cbr_flag_fsm
    import cbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd_i,
    input  flag_state_t result_i,
    output flag_bits_t  flags_o
);

    flag_state_t state_q;
    flag_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: if (upd_i) state_d = result_i;
            FL_EQ:    if (upd_i) state_d = result_i;
            FL_GT:    if (upd_i) state_d = result_i;
            FL_LT:    if (upd_i) state_d = result_i;
        endcase
    end

    always_comb begin
        flags_o = '0;
        unique case (state_q)
            FL_CLEAR: flags_o = '0;
            FL_EQ:    flags_o.eq = 1'b1;
            FL_GT:    flags_o.gt = 1'b1;
            FL_LT:    flags_o.lt = 1'b1;
        endcase
    end

    // R2: a written state is always one of the three outcome states
    a_r2_no_clear_after_update: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> (state_q != FL_CLEAR));

endmodule

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
    import cbr_pkg::*;
(
    input  logic             exec_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  flag_bits_t       flags_i,
    output logic             taken_o
);

    logic cond;

    always_comb begin
        cond = 1'b0;
        unique case (opcode_i)
            OP_JMP:  cond = 1'b1;
            OP_JEQ:  cond = flags_i.eq;
            OP_JNE:  cond = !flags_i.eq;
            OP_JGT:  cond = flags_i.gt;
            OP_JGE:  cond = flags_i.gt | flags_i.eq;
            OP_JLT:  cond = flags_i.lt;
            OP_JLE:  cond = flags_i.lt | flags_i.eq;
            default: cond = 1'b0;
        endcase
    end

    assign taken_o = exec_i & cond;

endmodule

// File: rtl/cbr_target_gen.sv
module cbr_target_gen #(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 16,
    parameter int OFF_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFF_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] target_o
);

    localparam int EXT_W = ADDR_W - OFF_W - OFF_SHIFT;

    logic [ADDR_W-1:0] disp;

    generate
        if (OFF_SHIFT > 0) begin : g_scaled
            assign disp = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, {OFF_SHIFT{1'b0}}};
        end else begin : g_unscaled
            assign disp = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
        end
    endgenerate

    assign target_o = pc_i + disp;

endmodule

// File: rtl/cbr_resolver.sv
module cbr_resolver
    import cbr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 16,
    parameter int OFF_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [5:0]        opcode_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFF_W-1:0]  offset_i,
    output logic              flag_eq_o,
    output logic              flag_gt_o,
    output logic              flag_lt_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] target_o
);

    flag_state_t cmp_res;
    flag_bits_t  flags;
    logic        cmp_upd;

    assign cmp_upd = exec_i && (opcode_i == OP_CMP);

    cbr_compare #(.DATA_W(DATA_W)) u_cmp (
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .result_o (cmp_res)
    );

    cbr_flag_fsm u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_i    (cmp_upd),
        .result_i (cmp_res),
        .flags_o  (flags)
    );

    cbr_cond_eval u_cond (
        .exec_i   (exec_i),
        .opcode_i (opcode_i),
        .flags_i  (flags),
        .taken_o  (taken_o)
    );

    cbr_target_gen #(
        .ADDR_W    (ADDR_W),
        .OFF_W     (OFF_W),
        .OFF_SHIFT (OFF_SHIFT)
    ) u_tgt (
        .pc_i     (pc_i),
        .offset_i (offset_i),
        .target_o (target_o)
    );

    assign flag_eq_o = flags.eq;
    assign flag_gt_o = flags.gt;
    assign flag_lt_o = flags.lt;

    a_r2_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_upd |=> ($countones({flag_eq_o, flag_gt_o, flag_lt_o}) == 1));

    a_r2_eq_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_upd && (opa_i == opb_i)) |=> flag_eq_o);

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_upd |=> $stable({flag_eq_o, flag_gt_o, flag_lt_o}));

    a_r4_jmp_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && opcode_i == OP_JMP) |-> taken_o);

    a_r5_jeq_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && opcode_i == OP_JEQ) |-> (taken_o == flag_eq_o));

    a_r9_idle_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |-> !taken_o);

    a_r2_flags_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_eq_o, flag_gt_o, flag_lt_o}));

endmodule

// File: tb/cbr_resolver_tb_top.sv
module cbr_resolver_tb_top;

    logic        clk;
    logic        rst_n;
    logic        exec_i;
    logic [5:0]  opcode_i;
    logic [31:0] opa_i;
    logic [31:0] opb_i;
    logic [31:0] pc_i;
    logic [15:0] offset_i;
    logic        flag_eq_o;
    logic        flag_gt_o;
    logic        flag_lt_o;
    logic        taken_o;
    logic [31:0] target_o;

    int checks;
    int fails;
    bit m_eq, m_gt, m_lt;

    cbr_resolver dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_i    (exec_i),
        .opcode_i  (opcode_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .pc_i      (pc_i),
        .offset_i  (offset_i),
        .flag_eq_o (flag_eq_o),
        .flag_gt_o (flag_gt_o),
        .flag_lt_o (flag_lt_o),
        .taken_o   (taken_o),
        .target_o  (target_o)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic bit exp_taken(bit ex, logic [5:0] op, bit eq, bit gt, bit lt);
        if (!ex) return 1'b0;
        case (op)
            6'h0D: return 1'b1;
            6'h0E: return eq;
            6'h0F: return !eq;
            6'h10: return gt;
            6'h11: return gt | eq;
            6'h12: return lt;
            6'h13: return lt | eq;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_target(logic [31:0] pc, logic [15:0] off);
        logic signed [31:0] d;
        d = 32'(signed'(off));
        return pc + (d <<< 2);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_flags(string req);
        check({flag_eq_o, flag_gt_o, flag_lt_o} == {m_eq, m_gt, m_lt}, req,
              {29'd0, flag_eq_o, flag_gt_o, flag_lt_o}, {29'd0, m_eq, m_gt, m_lt});
    endtask

    task automatic step(bit ex, logic [5:0] op, logic [31:0] a, logic [31:0] b,
                        logic [31:0] pc, logic [15:0] off, string req);
        bit et;
        logic [31:0] etg;
        @(negedge clk);
        exec_i = ex; opcode_i = op; opa_i = a; opb_i = b; pc_i = pc; offset_i = off;
        #1;
        et = exp_taken(ex, op, m_eq, m_gt, m_lt);
        etg = exp_target(pc, off);
        check(taken_o == et, req, {31'd0, taken_o}, {31'd0, et});
        check(target_o == etg, "R8", target_o, etg);
        @(posedge clk);
        #1;
        if (ex && op == 6'h14) begin
            m_eq = (a == b);
            m_gt = ($signed(a) > $signed(b));
            m_lt = ($signed(a) < $signed(b));
        end
        check_flags(req);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        checks = 0; fails = 0;
        m_eq = 0; m_gt = 0; m_lt = 0;
        exec_i = 0; opcode_i = 0; opa_i = 0; opb_i = 0; pc_i = 0; offset_i = 0;
        rst_n = 0;
        seed = $urandom(32'd20250627);
        repeat (3) @(posedge clk);
        #1;
        check_flags("R1 reset flags");
        check(taken_o == 1'b0, "R1 idle taken", {31'd0, taken_o}, 32'd0);
        @(negedge clk);
        rst_n = 1;

        // R5: from clear state JNE taken, JEQ not; R6/R7 not taken
        step(1, 6'h0F, 0, 0, 32'h100, 16'h0004, "R5 jne from clear");
        step(1, 6'h0E, 0, 0, 32'h100, 16'h0004, "R5 jeq from clear");
        step(1, 6'h11, 0, 0, 32'h100, 16'h0004, "R6 jge from clear");
        step(1, 6'h13, 0, 0, 32'h100, 16'h0004, "R7 jle from clear");
        // R2/R10: signed extremes, jump right after compare
        step(1, 6'h14, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, "R2 max vs min");
        step(1, 6'h10, 0, 0, 32'h200, 16'hFFFF, "R10 jgt after cmp");
        step(1, 6'h14, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, "R2 -1 vs 1");
        step(1, 6'h12, 0, 0, 32'h200, 16'h8000, "R10 jlt after cmp");
        step(1, 6'h14, 32'h1234_5678, 32'h1234_5678, 0, 0, "R2 equal");
        step(1, 6'h13, 0, 0, 32'h0, 16'h8000, "R7 jle on eq");
        step(1, 6'h11, 0, 0, 32'hFFFF_FFFC, 16'h0001, "R6 jge on eq / R8 wrap");
        // R3: ignored compare and non-compare opcodes
        step(0, 6'h14, 32'h5, 32'h9, 0, 0, "R3 cmp without exec");
        step(1, 6'h19, 32'h5, 32'h9, 0, 0, "R3 other opcode");
        step(1, 6'h0D, 32'h5, 32'h9, 32'h40, 16'h0010, "R4 jmp");
        step(0, 6'h0D, 0, 0, 32'h40, 16'h0010, "R9 no exec");
        step(1, 6'h15, 0, 0, 32'h40, 16'h0010, "R9 non jump");

        for (int i = 0; i < 400; i++) begin
            logic [5:0]  op;
            logic [31:0] a, b;
            bit ex;
            case ($urandom_range(0, 3))
                0: op = 6'h14;
                1, 2: op = 6'(6'h0D + $urandom_range(0, 6));
                default: op = 6'($urandom_range(0, 63));
            endcase
            a = $urandom();
            b = ($urandom_range(0, 3) == 0) ? a : $urandom();
            ex = ($urandom_range(0, 7) != 0);
            step(ex, op, a, b, $urandom(), 16'($urandom()), "R2-R9 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule